// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block keeps a small set of recent virtual-to-physical page mappings so that most address translations avoid a walk of the in-memory page tables. Each stored mapping is tagged with both the virtual page number and the identifier of the process that owns it. Several processes can therefore keep mappings in the cache side by side, and a context switch does not force the cache to be emptied.

A lookup presents a virtual page number and the current process identifier. In the same cycle the block returns a hit flag, the physical page number and the protection bits. When a lookup misses, the block raises a miss request that carries the virtual page number, so that an external page walker can fetch the entry. The walker hands the result back through the fill port. Two flush controls are provided. One clears the whole cache. The other clears only the mappings that belong to one process identifier. Any mapping may be placed in any slot.

Top module: `xlat_cache`

## Requirements
- R1: When `lk_valid` is high and a valid slot holds the same virtual page number and process identifier, `lk_hit` is high in that same cycle and `lk_ppn`/`lk_perm` carry that slot's contents. When there is no hit, `lk_ppn` and `lk_perm` are zero.
- R2: A hit requires the process identifier to match as well as the page number. The same page number stored under two identifiers gives two independent mappings.
- R3: When `lk_valid` is high and there is no hit, `miss_req` is high and `miss_vpn` equals `lk_vpn`. When `lk_valid` is low, neither `lk_hit` nor `miss_req` is asserted.
- R4: A fill that matches no existing mapping is written into the lowest-numbered invalid slot.
- R5: When all slots are valid, a new fill replaces the slot named by a rotating pointer. The pointer starts at slot 0 after reset, advances by one only on such a replacement, and wraps after the last slot.
- R6: A fill whose page number and process identifier equal those of a valid slot overwrites that slot. No duplicate is created.
- R7: `flush_all` invalidates every slot at the next clock edge.
- R8: `flush_pid_en` invalidates only the slots whose process identifier equals `flush_pid`. All other slots keep their mappings.
- R9: When a flush and a fill happen in the same cycle, the flush takes effect first and the filled mapping is then present.
- R10: After reset, every slot is invalid and the replacement pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_pid | input | 8 | Current process identifier |
| lk_hit | output | 1 | Translation found |
| lk_ppn | output | 20 | Physical page number on a hit |
| lk_perm | output | 3 | Protection bits on a hit |
| miss_req | output | 1 | Request for a page walk |
| miss_vpn | output | 20 | Page number that missed |
| fill_en | input | 1 | Write a walked mapping |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_pid | input | 8 | Fill process identifier |
| fill_ppn | input | 20 | Fill physical page number |
| fill_perm | input | 3 | Fill protection bits |
| flush_all | input | 1 | Invalidate all slots |
| flush_pid_en | input | 1 | Invalidate slots of one process |
| flush_pid | input | 8 | Process identifier to flush |

## Verification
The hardest behaviour to reach from the ports is replacement after holes have opened in a full cache. The rotating pointer must already have moved, and a per-process flush must have freed slots in the middle of the array. The stimulus fills all sixteen slots, forces two replacements, and then flushes one process whose mappings sit in known middle slots. It then checks that new fills take the holes in ascending order before the pointer resumes at the slot where it stopped. A reference model in the bench tracks slot positions, so every surviving mapping is looked up again after each phase.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VPN_W  = 20;
    localparam int PID_W  = 8;
    localparam int PPN_W  = 20;
    localparam int PERM_W = 3;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PID_W-1:0]  pid;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } xlat_ent_t;

    function automatic logic tag_eq(xlat_ent_t e, logic [VPN_W-1:0] vpn,
                                    logic [PID_W-1:0] pid);
        return (e.vpn == vpn) && (e.pid == pid);
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  xlat_ent_t [ENTRIES-1:0]   ents,
    input  logic [ENTRIES-1:0]        valid,
    input  logic [VPN_W-1:0]          vpn,
    input  logic [PID_W-1:0]          pid,
    output logic [ENTRIES-1:0]        hit_vec
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = valid[i] && tag_eq(ents[i], vpn, pid);
    end

    // Fills never duplicate a tag, so at most one slot can match.
    assert_single_match_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fill_en,
    input  logic [ENTRIES-1:0]   valid_post,
    input  logic [ENTRIES-1:0]   dup_vec,
    output logic [IDX_W-1:0]     fill_idx
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             has_dup;
    logic             has_free;
    logic             replace;

    always_comb begin
        dup_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (dup_vec[i])     dup_idx  = IDX_W'(i);
            if (!valid_post[i]) free_idx = IDX_W'(i);
        end
    end

    assign has_dup  = |dup_vec;
    assign has_free = ~&valid_post;
    assign replace  = fill_en && !has_dup && !has_free;

    always_comb begin
        if (has_dup)       fill_idx = dup_idx;
        else if (has_free) fill_idx = free_idx;
        else               fill_idx = rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (replace) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    assert_fill_takes_free_R4: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !has_dup && has_free) |-> !valid_post[fill_idx]);

    assert_rr_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !replace |=> $stable(rr_q));

endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush_all,
    input  logic                      flush_pid_en,
    input  logic [PID_W-1:0]          flush_pid,
    input  logic                      fill_en,
    input  logic [IDX_W-1:0]          fill_idx,
    input  xlat_ent_t                 fill_ent,
    output xlat_ent_t [ENTRIES-1:0]   ents,
    output logic [ENTRIES-1:0]        valid,
    output logic [ENTRIES-1:0]        valid_post
);

    logic [ENTRIES-1:0] kill;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_kill
        assign kill[i] = flush_all || (flush_pid_en && ents[i].pid == flush_pid);
    end

    assign valid_post = valid & ~kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            ents  <= '0;
        end else begin
            valid <= valid_post;
            if (fill_en) begin
                valid[fill_idx] <= 1'b1;
                ents[fill_idx]  <= fill_ent;
            end
        end
    end

    assert_flush_all_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (flush_all && !fill_en) |=> (valid == '0));

    assert_fill_lands_R9: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (valid[$past(fill_idx)] && ents[$past(fill_idx)] == $past(fill_ent)));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm,
    output logic              miss_req,
    output logic [VPN_W-1:0]  miss_vpn,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PID_W-1:0]  fill_pid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              flush_all,
    input  logic              flush_pid_en,
    input  logic [PID_W-1:0]  flush_pid
);

    xlat_ent_t [ENTRIES-1:0] ents;
    logic [ENTRIES-1:0]      valid;
    logic [ENTRIES-1:0]      valid_post;
    logic [ENTRIES-1:0]      lk_vec;
    logic [ENTRIES-1:0]      dup_vec;
    logic [IDX_W-1:0]        fill_idx;
    xlat_ent_t               fill_ent;

    assign fill_ent = '{vpn: fill_vpn, pid: fill_pid, ppn: fill_ppn, perm: fill_perm};

    xlat_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst),
        .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_ent(fill_ent),
        .ents(ents), .valid(valid), .valid_post(valid_post)
    );

    xlat_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .clk(clk), .rst(rst), .ents(ents), .valid(valid),
        .vpn(lk_vpn), .pid(lk_pid), .hit_vec(lk_vec)
    );

    xlat_match #(.ENTRIES(ENTRIES)) u_fill_match (
        .clk(clk), .rst(rst), .ents(ents), .valid(valid_post),
        .vpn(fill_vpn), .pid(fill_pid), .hit_vec(dup_vec)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst(rst), .fill_en(fill_en),
        .valid_post(valid_post), .dup_vec(dup_vec), .fill_idx(fill_idx)
    );

    always_comb begin
        lk_ppn  = '0;
        lk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_valid && lk_vec[i]) begin
                lk_ppn  = lk_ppn  | ents[i].ppn;
                lk_perm = lk_perm | ents[i].perm;
            end
        end
    end

    assign lk_hit   = lk_valid && (|lk_vec);
    assign miss_req = lk_valid && !(|lk_vec);
    assign miss_vpn = lk_vpn;

    assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && miss_req));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !miss_req));

    assert_miss_zero_data_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_ppn == '0 && lk_perm == '0));

endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_pid = '0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic [2:0]  lk_perm;
    logic        miss_req;
    logic [19:0] miss_vpn;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_pid = '0;
    logic [19:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush_all = 1'b0;
    logic        flush_pid_en = 1'b0;
    logic [7:0]  flush_pid = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_cache u0 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
        .miss_req(miss_req), .miss_vpn(miss_vpn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model built from the requirements
    logic        m_v    [N];
    logic [19:0] m_vpn  [N];
    logic [7:0]  m_pid  [N];
    logic [19:0] m_ppn  [N];
    logic [2:0]  m_perm [N];
    int          m_rr;

    typedef struct {
        logic        hit;
        logic [19:0] ppn;
        logic [2:0]  perm;
        logic        miss;
        logic [19:0] mvpn;
        string       req;
    } exp_t;

    exp_t sb[$];

    task automatic report(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare design outputs against queued expectations
    always @(negedge clk) begin
        if (lk_valid && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            report(e.req, "hit",  lk_hit,   e.hit);
            report(e.req, "ppn",  lk_ppn,   e.ppn);
            report(e.req, "perm", lk_perm,  e.perm);
            report(e.req, "miss", miss_req, e.miss);
            if (e.miss) report(e.req, "miss_vpn", miss_vpn, e.mvpn);
        end
    end

    task automatic idle_inputs();
        lk_valid = 0; fill_en = 0; flush_all = 0; flush_pid_en = 0;
    endtask

    task automatic lookup(logic [19:0] vpn, logic [7:0] pid, string req);
        exp_t e;
        @(posedge clk); #1;
        idle_inputs();
        lk_valid = 1; lk_vpn = vpn; lk_pid = pid;
        e.hit = 0; e.ppn = 0; e.perm = 0; e.miss = 1; e.mvpn = vpn; e.req = req;
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) begin
                e.hit = 1; e.miss = 0; e.ppn = m_ppn[i]; e.perm = m_perm[i];
            end
        sb.push_back(e);
    endtask

    // One cycle of control: optional flushes and optional fill
    task automatic op(logic fa, logic fp, logic [7:0] fpid, logic fe,
                      logic [19:0] vpn, logic [7:0] pid, logic [19:0] ppn, logic [2:0] perm);
        int slot;
        @(posedge clk); #1;
        idle_inputs();
        flush_all = fa; flush_pid_en = fp; flush_pid = fpid;
        fill_en = fe; fill_vpn = vpn; fill_pid = pid; fill_ppn = ppn; fill_perm = perm;
        for (int i = 0; i < N; i++)
            if (fa || (fp && m_pid[i] == fpid)) m_v[i] = 0;
        if (fe) begin
            slot = -1;
            for (int i = 0; i < N; i++)
                if (slot < 0 && m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) slot = i;
            for (int i = 0; i < N; i++)
                if (slot < 0 && !m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[slot] = 1; m_vpn[slot] = vpn; m_pid[slot] = pid;
            m_ppn[slot] = ppn; m_perm[slot] = perm;
        end
    endtask

    task automatic fill(logic [19:0] vpn, logic [7:0] pid, logic [19:0] ppn, logic [2:0] perm);
        op(0, 0, 0, 1, vpn, pid, ppn, perm);
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < N; i++)
            if (m_v[i]) lookup(m_vpn[i], m_pid[i], req);
    endtask

    task automatic drain();
        @(posedge clk); #1;
        idle_inputs();
        @(posedge clk); #1;
    endtask

    bit done = 0;

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_vpn[i] = 0; m_pid[i] = 0; m_ppn[i] = 0; m_perm[i] = 0;
        end
        m_rr = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R10: reset leaves everything invalid; R3 miss request
        lookup(20'h00000, 8'h00, "R10");
        lookup(20'h12345, 8'h07, "R3");

        // R1 basic fills and hits
        fill(20'h00100, 8'h01, 20'hA0100, 3'b101);
        fill(20'h00200, 8'h01, 20'hA0200, 3'b011);
        fill(20'h00300, 8'h02, 20'hA0300, 3'b111);
        check_all("R1");
        lookup(20'h00400, 8'h01, "R3");

        // R2 same page, other process
        lookup(20'h00100, 8'h02, "R2");
        fill(20'h00100, 8'h02, 20'hB0100, 3'b001);
        lookup(20'h00100, 8'h01, "R2");
        lookup(20'h00100, 8'h02, "R2");

        // R6 refill of an existing tag overwrites it (old sits in slot 0)
        fill(20'h00100, 8'h01, 20'hC0100, 3'b110);
        lookup(20'h00100, 8'h01, "R6");
        check_all("R6");

        // R3 idle lookup on a present mapping
        drain();
        lk_vpn = 20'h00200; lk_pid = 8'h01;
        @(negedge clk);
        report("R3", "idle_hit", lk_hit, 0);
        report("R3", "idle_miss", miss_req, 0);

        // R8 flush one process only
        op(0, 1, 8'h01, 0, 0, 0, 0, 0);
        lookup(20'h00100, 8'h01, "R8");
        lookup(20'h00200, 8'h01, "R8");
        check_all("R8");

        // R7 flush everything
        op(1, 0, 0, 0, 0, 0, 0, 0);
        lookup(20'h00300, 8'h02, "R7");
        lookup(20'h00100, 8'h02, "R7");

        // R4/R5: fill every slot in order, then replace twice
        for (int i = 0; i < N; i++)
            fill(20'h01000 + 20'(i), (i == 5 || i == 9) ? 8'h33 : 8'h44,
                 20'hD0000 + 20'(i), 3'(i));
        check_all("R4");
        fill(20'h02000, 8'h44, 20'hE0000, 3'b010);
        fill(20'h02001, 8'h44, 20'hE0001, 3'b100);
        lookup(20'h01000, 8'h44, "R5");
        lookup(20'h01001, 8'h44, "R5");
        check_all("R5");

        // R4 holes in the middle are used before the pointer resumes
        op(0, 1, 8'h33, 0, 0, 0, 0, 0);
        fill(20'h03000, 8'h55, 20'hF0000, 3'b001);
        fill(20'h03001, 8'h55, 20'hF0001, 3'b011);
        check_all("R4");
        fill(20'h03002, 8'h55, 20'hF0002, 3'b111);
        lookup(20'h01002, 8'h44, "R5");
        check_all("R5");

        // R9 flush and fill in the same cycle
        op(1, 0, 0, 1, 20'h04000, 8'h66, 20'h14000, 3'b101);
        lookup(20'h04000, 8'h66, "R9");
        lookup(20'h03000, 8'h55, "R9");
        op(0, 1, 8'h66, 1, 20'h04001, 8'h66, 20'h14001, 3'b110);
        lookup(20'h04001, 8'h66, "R9");
        lookup(20'h04000, 8'h66, "R9");

        drain();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule